// File: doc/BRIEF.md
# Programmable pin waveform formatter

This block shapes the drive waveform of a single tester channel over one vector period. A tick counter splits each vector into `period_ticks` sub-period steps. A timing window opens at a leading-edge tick and closes at a trailing-edge tick. For every vector the pattern source supplies one data bit, and a format code chooses which value is driven inside the window and which value is driven outside it. As a result, the same data bit can come out as a held level, a pulse, a surrounded pulse or a short driven burst between high-impedance stretches.

A vector starts with a one-cycle pulse on `vec_strobe`. On that edge the block captures the period, both edge ticks, the format code and the data bit, so the edge timing may change from one vector to the next. If the next strobe arrives on the last tick of a period, vectors run back to back with no gap. If no strobe arrives, the channel goes idle after the period and holds its outside-window value. The pin outputs are registered, so the drive level and its enable change only on clock edges.

Top module: `pin_wave_formatter`

## Requirements
- R1: Period, edge ticks, format code and data bit are sampled only on the edge where `vec_strobe` is high. Changes on those inputs at any other time have no effect on the running vector.
- R2: The strobe edge restarts the tick counter at 0. The pin outputs in the cycle after edge k+1 (edge 0 being the strobe edge) show tick k, for k = 0 to period-1. After the last tick the channel is idle and drives the value the format gives outside the window.
- R3: The window holds the ticks t with lead <= t < trail.
- R4: Format code 0 (non-return) drives continuously. The pin takes the data value at the leading-edge tick and holds it into later vectors until another code-0 vector reaches its leading edge. The level after reset is 0.
- R5: Format code 1 (return low) drives the data value inside the window and 0 outside it, so data 0 never produces a high level.
- R6: Format code 2 (return high) drives the data value inside the window and 1 outside it, so only data 0 produces a pulse, and that pulse is low.
- R7: Format code 3 (surround by complement) drives the data value inside the window and its inverse outside it.
- R8: Format code 4 (return to high impedance) asserts `pin_oe` only inside the window and drives the data value there. Whenever `pin_oe` is low, `pin_drive` is 0.
- R9: A vector is illegal if trail <= lead, trail > period, period = 0, or the format code is 5, 6 or 7. `cfg_illegal` is high from the cycle after the strobe edge until the next strobe. Such a vector, and the idle time after it, keep `pin_oe` and `pin_drive` at 0.
- R10: A strobe during a running vector ends that vector at once: the tick shown in the next output cycle is tick 0 of the new vector. A strobe on the last tick gives seamless back-to-back vectors.
- R11: While `rst_n` is low, and right after it, `pin_drive`, `pin_oe` and `cfg_illegal` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock |
| rst_n | input | 1 | Synchronous active-low reset |
| period_ticks | input | TICK_W | Vector period length in ticks |
| lead_tick | input | TICK_W | Tick at which the window opens |
| trail_tick | input | TICK_W | Tick at which the window closes (exclusive) |
| fmt_sel | input | 3 | Format code: 0 non-return, 1 return low, 2 return high, 3 surround, 4 return to high impedance |
| vec_data | input | 1 | Pattern data bit for the vector |
| vec_strobe | input | 1 | One-cycle pulse that starts a vector |
| pin_drive | output | 1 | Level driven on the pin |
| pin_oe | output | 1 | Drive enable; low means high impedance |
| cfg_illegal | output | 1 | Captured edge or format setting is illegal |

## Verification
The bench sweeps every legal lead/trail pair of an 8-tick period, in all five formats, with both data values, and predicts the output tick by tick. This catches a window that is one tick off at either edge (a wrong comparison at the leading or trailing tick), and a return-high or surround format that swaps the inside and outside values. Non-return vectors are chained so that a level which fails to carry across periods, or which updates at the strobe instead of the leading edge, shows up in the early ticks of the next vector. Illegal cases cover the trailing edge equal to the leading edge, the trailing edge one past the period, a zero period and the reserved codes; a design that let those drive would raise `pin_oe`. Early and last-tick restarts, and input changes in the middle of a vector, expose a counter that fails to reset or a configuration that is not captured at the strobe.

// File: rtl/pwf_pkg.sv
// Shared definitions for the pin waveform formatter.
// Assumes format codes are fixed by the test program encoding (0..4 valid).
package pwf_pkg;

    typedef enum logic [2:0] {
        FMT_NONRET   = 3'd0,
        FMT_RET_LO   = 3'd1,
        FMT_RET_HI   = 3'd2,
        FMT_SURROUND = 3'd3,
        FMT_RET_Z    = 3'd4
    } pwf_fmt_e;

    localparam logic [2:0] FMT_LAST_VALID = 3'd4;

endpackage

// File: rtl/pwf_vector_reg.sv
// Captures one vector's timing, format and data on the strobe edge and
// judges whether the capture is usable.
// Assumes vec_strobe is a single-cycle pulse; holds its values between strobes.
module pwf_vector_reg
    import pwf_pkg::*;
#(
    parameter int TICK_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vec_strobe,
    input  logic [TICK_W-1:0] period_ticks,
    input  logic [TICK_W-1:0] lead_tick,
    input  logic [TICK_W-1:0] trail_tick,
    input  logic [2:0]        fmt_sel,
    input  logic              vec_data,
    output logic [TICK_W-1:0] per_q,
    output logic [TICK_W-1:0] lead_q,
    output logic [TICK_W-1:0] trail_q,
    output pwf_fmt_e          fmt_q,
    output logic              data_q,
    output logic              ill_q
);

    logic bad_edges;
    logic bad_fmt;
    logic bad_now;

    // Legality of the values presented on the inputs this cycle.
    always_comb begin
        bad_edges = (trail_tick <= lead_tick) || (trail_tick > period_ticks);
        bad_fmt   = (fmt_sel > FMT_LAST_VALID);
        bad_now   = bad_edges || bad_fmt || (period_ticks == '0);
    end

    // Vector capture register, loaded only by the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_q   <= '0;
            lead_q  <= '0;
            trail_q <= '0;
            fmt_q   <= FMT_RET_Z;
            data_q  <= 1'b0;
            ill_q   <= 1'b0;
        end else if (vec_strobe) begin
            per_q   <= period_ticks;
            lead_q  <= lead_tick;
            trail_q <= trail_tick;
            fmt_q   <= pwf_fmt_e'(fmt_sel);
            data_q  <= vec_data;
            ill_q   <= bad_now;
        end
    end

endmodule

// File: rtl/pwf_tick_counter.sv
// Sub-period tick counter: restarts at 0 on a strobe and runs through
// period-1, then goes idle.
// Assumes per_q is the captured period; a zero period ends after one tick.
module pwf_tick_counter #(
    parameter int TICK_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vec_strobe,
    input  logic [TICK_W-1:0] per_q,
    output logic              active_q,
    output logic [TICK_W-1:0] tick_q
);

    logic [TICK_W:0] tick_inc;
    logic            at_last;

    // Next tick value and end-of-period detection, one bit wider to avoid wrap.
    always_comb begin
        tick_inc = {1'b0, tick_q} + {{TICK_W{1'b0}}, 1'b1};
        at_last  = (tick_inc >= {1'b0, per_q});
    end

    // Counter and running flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            tick_q   <= '0;
        end else if (vec_strobe) begin
            active_q <= 1'b1;
            tick_q   <= '0;
        end else if (active_q) begin
            if (at_last) begin
                active_q <= 1'b0;
            end else begin
                tick_q <= tick_inc[TICK_W-1:0];
            end
        end
    end

endmodule

// File: rtl/pwf_wave_shaper.sv
// Forms the pin level and drive enable from the window and the format.
// Assumes the counter and capture registers are stable for the current
// tick; outputs are registered one cycle behind the tick.
module pwf_wave_shaper
    import pwf_pkg::*;
#(
    parameter int TICK_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active_q,
    input  logic [TICK_W-1:0] tick_q,
    input  logic [TICK_W-1:0] lead_q,
    input  logic [TICK_W-1:0] trail_q,
    input  pwf_fmt_e          fmt_q,
    input  logic              data_q,
    input  logic              ill_q,
    output logic              pin_drive,
    output logic              pin_oe
);

    logic in_win;
    logic lead_hit;
    logic level_q;
    logic level_n;
    logic pin_n;
    logic oe_n;

    // Window membership and leading-edge tick for the current vector.
    always_comb begin
        in_win   = active_q && (tick_q >= lead_q) && (tick_q < trail_q);
        lead_hit = active_q && (tick_q == lead_q);
    end

    // Held level for non-return format, updated only at its leading edge.
    always_comb begin
        level_n = level_q;
        if (!ill_q && fmt_q == FMT_NONRET && lead_hit) begin
            level_n = data_q;
        end
    end

    // Per-format selection of inside and outside values.
    always_comb begin
        pin_n = 1'b0;
        oe_n  = 1'b0;
        if (!ill_q) begin
            case (fmt_q)
                FMT_NONRET: begin
                    pin_n = level_n;
                    oe_n  = 1'b1;
                end
                FMT_RET_LO: begin
                    pin_n = in_win & data_q;
                    oe_n  = 1'b1;
                end
                FMT_RET_HI: begin
                    pin_n = in_win ? data_q : 1'b1;
                    oe_n  = 1'b1;
                end
                FMT_SURROUND: begin
                    pin_n = in_win ? data_q : ~data_q;
                    oe_n  = 1'b1;
                end
                FMT_RET_Z: begin
                    pin_n = in_win & data_q;
                    oe_n  = in_win;
                end
                default: begin
                    pin_n = 1'b0;
                    oe_n  = 1'b0;
                end
            endcase
        end
    end

    // Output and held-level registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_drive <= 1'b0;
            pin_oe    <= 1'b0;
            level_q   <= 1'b0;
        end else begin
            pin_drive <= pin_n;
            pin_oe    <= oe_n;
            level_q   <= level_n;
        end
    end

endmodule

// File: rtl/pin_wave_formatter.sv
// Top of the per-channel waveform formatter: vector capture, tick counter
// and wave shaper in series.
// Assumes one strobe per vector and a clock equal to the tick rate.
module pin_wave_formatter
    import pwf_pkg::*;
#(
    parameter int TICK_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TICK_W-1:0] period_ticks,
    input  logic [TICK_W-1:0] lead_tick,
    input  logic [TICK_W-1:0] trail_tick,
    input  logic [2:0]        fmt_sel,
    input  logic              vec_data,
    input  logic              vec_strobe,
    output logic              pin_drive,
    output logic              pin_oe,
    output logic              cfg_illegal
);

    logic [TICK_W-1:0] per_q;
    logic [TICK_W-1:0] lead_q;
    logic [TICK_W-1:0] trail_q;
    pwf_fmt_e          fmt_q;
    logic              data_q;
    logic              ill_q;
    logic              active_q;
    logic [TICK_W-1:0] tick_q;

    pwf_vector_reg #(.TICK_W(TICK_W)) u_vec (
        .clk          (clk),
        .rst_n        (rst_n),
        .vec_strobe   (vec_strobe),
        .period_ticks (period_ticks),
        .lead_tick    (lead_tick),
        .trail_tick   (trail_tick),
        .fmt_sel      (fmt_sel),
        .vec_data     (vec_data),
        .per_q        (per_q),
        .lead_q       (lead_q),
        .trail_q      (trail_q),
        .fmt_q        (fmt_q),
        .data_q       (data_q),
        .ill_q        (ill_q)
    );

    pwf_tick_counter #(.TICK_W(TICK_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .vec_strobe (vec_strobe),
        .per_q      (per_q),
        .active_q   (active_q),
        .tick_q     (tick_q)
    );

    pwf_wave_shaper #(.TICK_W(TICK_W)) u_shape (
        .clk       (clk),
        .rst_n     (rst_n),
        .active_q  (active_q),
        .tick_q    (tick_q),
        .lead_q    (lead_q),
        .trail_q   (trail_q),
        .fmt_q     (fmt_q),
        .data_q    (data_q),
        .ill_q     (ill_q),
        .pin_drive (pin_drive),
        .pin_oe    (pin_oe)
    );

    // Flag is the captured legality verdict.
    assign cfg_illegal = ill_q;

endmodule

// File: rtl/pwf_checker.sv
// Temporal checks on the waveform formatter, attached by bind.
// Assumes it observes the top's ports and its capture and counter state.
module pwf_checker #(
    parameter int TICK_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              vec_strobe,
    input logic              pin_drive,
    input logic              pin_oe,
    input logic              cfg_illegal,
    input logic              active,
    input logic [TICK_W-1:0] tick,
    input logic [TICK_W-1:0] per,
    input logic [2:0]        fmt,
    input logic              data
);

    assert_strobe_restarts_R1: assert property (@(posedge clk) disable iff (!rst_n)
        vec_strobe |=> (active && tick == '0));

    // R10: restart also applies when a vector is running
    assert_restart_midrun_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_strobe && active) |=> (tick == '0));

    assert_tick_in_period_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (active && per != '0) |-> (tick < per));

    assert_ret_lo_no_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt == 3'd1 && !data && !cfg_illegal) |=> !pin_drive);

    assert_ret_hi_idle_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt == 3'd2 && !cfg_illegal && !active) |=> pin_drive);

    // R7 also relies on this: solid formats always drive
    assert_solid_formats_drive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((fmt == 3'd1 || fmt == 3'd2 || fmt == 3'd3) && !cfg_illegal) |=> pin_oe);

    assert_float_is_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_oe |-> !pin_drive);

    assert_illegal_floats_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_illegal |=> !pin_oe);

    assert_reset_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!pin_oe && !pin_drive && !cfg_illegal));

endmodule

bind pin_wave_formatter pwf_checker #(.TICK_W(TICK_W)) i_pwf_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .vec_strobe  (vec_strobe),
    .pin_drive   (pin_drive),
    .pin_oe      (pin_oe),
    .cfg_illegal (cfg_illegal),
    .active      (active_q),
    .tick        (tick_q),
    .per         (per_q),
    .fmt         (fmt_q),
    .data        (data_q)
);

// File: tb/test_pin_wave_formatter.sv
// Self-checking sweep of the pin waveform formatter with a 4-bit tick field.
module test_pin_wave_formatter;

    localparam int CLK_PERIOD = 10;
    localparam int TW         = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [TW-1:0] period_ticks = '0;
    logic [TW-1:0] lead_tick = '0;
    logic [TW-1:0] trail_tick = '0;
    logic [2:0]    fmt_sel = '0;
    logic          vec_data = 1'b0;
    logic          vec_strobe = 1'b0;
    logic          pin_drive;
    logic          pin_oe;
    logic          cfg_illegal;

    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;
    bit    exp_level = 1'b0;
    string tag_override = "";
    bit    scramble = 1'b0;
    int    nx_f, nx_d, nx_l, nx_t, nx_p;

    pin_wave_formatter #(.TICK_W(TW)) i_pin_wave_formatter (
        .clk          (clk),
        .rst_n        (rst_n),
        .period_ticks (period_ticks),
        .lead_tick    (lead_tick),
        .trail_tick   (trail_tick),
        .fmt_sel      (fmt_sel),
        .vec_data     (vec_data),
        .vec_strobe   (vec_strobe),
        .pin_drive    (pin_drive),
        .pin_oe       (pin_oe),
        .cfg_illegal  (cfg_illegal)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic string fmt_tag(input int f, input bit ill);
        if (ill) return "R9";
        case (f)
            0: return "R4";
            1: return "R5";
            2: return "R6";
            3: return "R7";
            default: return "R8";
        endcase
    endfunction

    function automatic bit is_ill(input int f, l, t, p);
        return (f > 4) || (p == 0) || (t <= l) || (t > p);
    endfunction

    // Expected pin/oe given window membership (R3 window rule).
    task automatic expect_out(input int f, input bit d, input bit ill, input bit inw,
                              output bit ep, output bit eo);
        ep = 1'b0; eo = 1'b0;
        if (!ill) begin
            case (f)
                0: begin ep = exp_level; eo = 1'b1; end
                1: begin ep = inw & d;   eo = 1'b1; end
                2: begin ep = inw ? d : 1'b1; eo = 1'b1; end
                3: begin ep = inw ? d : ~d;   eo = 1'b1; end
                default: begin ep = inw & d; eo = inw; end
            endcase
        end
    endtask

    task automatic drive(input int f, d, l, t, p);
        fmt_sel      = f[2:0];
        vec_data     = d[0];
        lead_tick    = l[TW-1:0];
        trail_tick   = t[TW-1:0];
        period_ticks = p[TW-1:0];
    endtask

    // Runs one vector; called at a negedge. pre=1 means it was already strobed.
    task automatic run_vec(input int f, d, l, t, p, input bit pre, input int stop_k);
        bit    ill, inw, ep, eo;
        int    lim;
        string tg;
        if (!pre) begin
            drive(f, d, l, t, p);
            vec_strobe = 1'b1;
            @(negedge clk);
        end
        vec_strobe = 1'b0;
        if (scramble) drive(5, 1 - d, 0, 0, 0);
        ill = is_ill(f, l, t, p);
        chk("R9", "cfg_illegal", cfg_illegal, ill);
        lim = (p == 0) ? 1 : p;
        for (int k = 0; k < lim; k++) begin
            @(negedge clk);
            if (stop_k >= 0 && k == stop_k) begin
                drive(nx_f, nx_d, nx_l, nx_t, nx_p);
                vec_strobe = 1'b1;
            end
            inw = (k >= l) && (k < t);
            if (!ill && f == 0 && k == l) exp_level = d[0];
            expect_out(f, d[0], ill, inw, ep, eo);
            tg = (tag_override != "") ? tag_override : fmt_tag(f, ill);
            chk(tg, "pin_drive", pin_drive, ep);
            chk(tg, "pin_oe", pin_oe, eo);
            if (stop_k >= 0 && k == stop_k + 1) break;
        end
    endtask

    // R2: idle after the period holds the outside-window value.
    task automatic check_idle(input int f, d, l, t, p, input int n);
        bit ep, eo;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            expect_out(f, d[0], is_ill(f, l, t, p), 1'b0, ep, eo);
            chk("R2", "idle pin_drive", pin_drive, ep);
            chk("R2", "idle pin_oe", pin_oe, eo);
        end
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk("R11", "reset pin_drive", pin_drive, 1'b0);
        chk("R11", "reset pin_oe", pin_oe, 1'b0);
        chk("R11", "reset cfg_illegal", cfg_illegal, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11", "post-reset pin_oe", pin_oe, 1'b0);
        chk("R11", "post-reset cfg_illegal", cfg_illegal, 1'b0);

        // R3..R8: every legal window of an 8-tick period, all formats, both data values
        for (int f = 0; f < 5; f++)
            for (int d = 0; d < 2; d++)
                for (int l = 0; l < 8; l++)
                    for (int t = l + 1; t <= 8; t++) begin
                        run_vec(f, d, l, t, 8, 1'b0, -1);
                        check_idle(f, d, l, t, 8, 1);
                    end

        // R4: level carries into the next vector until its leading edge
        run_vec(0, 1, 3, 4, 8, 1'b0, -1);
        run_vec(0, 0, 5, 6, 8, 1'b0, -1);
        check_idle(0, 0, 5, 6, 8, 2);

        // R3: widest period and window at the top of the tick range
        run_vec(3, 1, 14, 15, 15, 1'b0, -1);
        run_vec(4, 1, 0, 15, 15, 1'b0, -1);

        // R9: illegal windows, periods and format codes
        run_vec(1, 1, 4, 4, 8, 1'b0, -1);   check_idle(1, 1, 4, 4, 8, 1);
        run_vec(2, 0, 5, 3, 8, 1'b0, -1);
        run_vec(3, 1, 2, 9, 8, 1'b0, -1);   check_idle(3, 1, 2, 9, 8, 1);
        run_vec(0, 1, 0, 1, 0, 1'b0, -1);   check_idle(0, 1, 0, 1, 0, 2);
        for (int f = 5; f < 8; f++) run_vec(f, 1, 1, 3, 8, 1'b0, -1);
        run_vec(3, 1, 2, 5, 8, 1'b0, -1);   // legal again after illegal

        // R10: seamless back-to-back and early restart
        nx_f = 3; nx_d = 0; nx_l = 0; nx_t = 2; nx_p = 6;
        tag_override = "R10";
        run_vec(1, 1, 1, 4, 6, 1'b0, 4);
        nx_f = 4; nx_d = 1; nx_l = 2; nx_t = 5; nx_p = 8;
        run_vec(3, 0, 0, 2, 6, 1'b1, 1);
        run_vec(4, 1, 2, 5, 8, 1'b1, -1);
        check_idle(4, 1, 2, 5, 8, 1);

        // R1: input changes mid-vector leave the captured vector untouched
        tag_override = "R1";
        scramble = 1'b1;
        run_vec(3, 1, 2, 6, 8, 1'b0, -1);
        run_vec(2, 0, 1, 3, 8, 1'b0, -1);
        scramble = 1'b0;
        tag_override = "";

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule